// File: doc/BRIEF.md
# Serial-to-Parallel Word Converter

This block turns a continuous serial bit stream into fixed-width parallel words. One data bit is taken on every rising edge of the input clock and pushed into a cascade of flip-flops. A chain of toggle stages divides the input clock down to a word clock. Each time that word clock completes a period, a hold register takes all the shifted bits at once and keeps them steady for the next word time.

The word clock is also driven out of the block. A consumer downstream can take the parallel word one input-clock cycle after the word clock rises. The block does no framing. Words begin where the free-running divider happens to be after reset is released, so the sender must align its stream to that reset.

The whole design runs on the input clock. The divider is a set of synchronous toggle bits, and the hold register loads through an enable when the divider wraps. There is no second clock domain.

Top module: `s2p_converter`

## Requirements
- R1: `ser_in` is sampled on every rising edge of `clk_in` while reset is low and enters the first stage of the shift cascade. Each stage passes its bit to the next stage on the following edge.
- R2: The parallel word is `WORD_W` bits wide, 8 by default. The first bit of a word appears on `par_out[7]` and the last on `par_out[0]`, so the serial sequence 1,0,0,1,1,0,0,1 yields `par_out` = 8'b10011001.
- R3: `par_out` changes only at a capture edge. Between capture edges it holds its value.
- R4: `word_clk` is `clk_in` divided by 8, with a 50% duty cycle: high for 4 input cycles and low for 4. It rises at the same edge at which `par_out` takes a new word.
- R5: A synchronous active-high `rst` clears the shift cascade, the hold register and the divider. While `rst` is high, `par_out` is 0 and `word_clk` is 1.
- R6: After `rst` is released, the first capture happens on the 8th rising edge of `clk_in`. Before that edge, `par_out` stays 0.
- R7: Words sent back to back with no gap are each captured whole, one every 8 input cycles, with no bit lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Bit clock. One serial bit is taken per rising edge. |
| rst | input | 1 | Synchronous active-high reset. |
| ser_in | input | 1 | Serial data input. |
| par_out | output | 8 | Captured parallel word. The first-received bit is at the MSB. |
| word_clk | output | 1 | Input clock divided by 8. Its rising edge marks a new word. |

## Verification
The assertions assume that `rst` is held high from time zero until the first edges have passed. They also assume that `ser_in` is stable around each rising edge of `clk_in`. The bench meets both conditions: it asserts reset before the first edge and changes `ser_in` and `rst` only on falling edges.

The assertions make no assumption about word alignment. The bench keeps its own count of edges since reset, and every word it sends starts on an edge count that is a multiple of 8. Reset is reasserted part-way through a word to show that a new alignment is set at the next release.

// File: rtl/s2p_pkg.sv
`timescale 1ns/1ps
package s2p_pkg;

  // Number of divide-by-2 toggle stages; the word is 2**stages bits long.
  localparam int unsigned S2P_DIV_STAGES = 3;

  // Toggle stage k flips when every lower stage is at 1 (synchronous ripple).
  function automatic logic stage_flips(input int unsigned k, input logic [31:0] state);
    logic [31:0] mask;
    mask = (32'd1 << k) - 32'd1;
    return (state & mask) == mask;
  endfunction

  // Next content of a shift cascade: older bits move toward the MSB.
  function automatic logic [31:0] shift_in(input logic [31:0] cur, input logic b);
    return {cur[30:0], b};
  endfunction

endpackage

// File: rtl/s2p_shift_chain.sv
`timescale 1ns/1ps
module s2p_shift_chain #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] stages_o
);

  logic [WORD_W-1:0] stage_q;

  // One flop per stage; stage 0 takes the serial bit, stage i takes stage i-1.
  for (genvar i = 0; i < WORD_W; i++) begin : g_stage
    logic d_in;
    if (i == 0) begin : g_head
      assign d_in = bit_i;
    end else begin : g_link
      assign d_in = stage_q[i-1];
    end
    always_ff @(posedge clk_i) begin
      if (rst_i) stage_q[i] <= 1'b0;
      else       stage_q[i] <= d_in;
    end
  end

  assign stages_o = stage_q;

  // R1: the serial bit sampled at one edge sits in the head stage afterwards.
  assert_head_sample_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> stage_q[0] == $past(bit_i));

  // R1: the last stage holds what the one before it held a cycle earlier.
  assert_cascade_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> stage_q[WORD_W-1] == $past(stage_q[WORD_W-2]));

endmodule

// File: rtl/s2p_word_divider.sv
`timescale 1ns/1ps
module s2p_word_divider
  import s2p_pkg::*;
#(
  parameter int unsigned STAGES = S2P_DIV_STAGES
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic word_clk_o,
  output logic wrap_o
);

  logic [STAGES-1:0] tap_q;
  logic [31:0]       tap_wide;

  assign tap_wide = 32'(tap_q);

  // Each toggle stage is a divide-by-2; together the taps are /2, /4, /8 ...
  for (genvar k = 0; k < STAGES; k++) begin : g_toggle
    logic flip;
    assign flip = stage_flips(k, tap_wide);
    always_ff @(posedge clk_i) begin
      if (rst_i)     tap_q[k] <= 1'b0;
      else if (flip) tap_q[k] <= ~tap_q[k];
    end
  end

  // Wrap event: every stage at 1, so the next edge returns all to 0.
  assign wrap_o     = &tap_q;
  assign word_clk_o = ~tap_q[STAGES-1];

  // R4: the first stage divides by two.
  assert_first_stage_toggles_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> tap_q[0] != $past(tap_q[0]));

  // R4: after a wrap the whole chain is back at zero.
  assert_wrap_clears_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_o |=> tap_q == '0);

endmodule

// File: rtl/s2p_hold_reg.sv
`timescale 1ns/1ps
module s2p_hold_reg #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);

  logic [WORD_W-1:0] hold_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       hold_q <= '0;
    else if (load_i) hold_q <= word_i;
  end

  assign word_o = hold_q;

  // R3: without a load the held word does not move.
  assert_hold_stable_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    !load_i |=> $stable(hold_q));

endmodule

// File: rtl/s2p_converter.sv
`timescale 1ns/1ps
module s2p_converter
  import s2p_pkg::*;
#(
  parameter int unsigned DIV_STAGES = S2P_DIV_STAGES
) (
  input  logic                       clk_in,
  input  logic                       rst,
  input  logic                       ser_in,
  output logic [(1<<DIV_STAGES)-1:0] par_out,
  output logic                       word_clk
);

  localparam int unsigned WORD_W = 1 << DIV_STAGES;

  logic [WORD_W-1:0] stages;
  logic [WORD_W-1:0] capture_word;
  logic [31:0]       capture_wide;
  logic              wrap_evt;

  s2p_shift_chain #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_in),
    .rst_i   (rst),
    .bit_i   (ser_in),
    .stages_o(stages)
  );

  s2p_word_divider #(.STAGES(DIV_STAGES)) u_div (
    .clk_i     (clk_in),
    .rst_i     (rst),
    .word_clk_o(word_clk),
    .wrap_o    (wrap_evt)
  );

  // The capture takes the cascade as it will be after this edge, so the
  // word in the hold register includes the bit arriving at the wrap edge.
  assign capture_wide = shift_in(32'(stages), ser_in);
  assign capture_word = capture_wide[WORD_W-1:0];

  s2p_hold_reg #(.WORD_W(WORD_W)) u_hold (
    .clk_i (clk_in),
    .rst_i (rst),
    .load_i(wrap_evt),
    .word_i(capture_word),
    .word_o(par_out)
  );

  // R4: the word clock rises exactly at a wrap edge.
  assert_wordclk_rise_at_wrap_R4: assert property (@(posedge clk_in) disable iff (rst)
    wrap_evt |=> $rose(word_clk));

  // R4: no rise of the word clock happens away from a wrap.
  assert_no_stray_rise_R4: assert property (@(posedge clk_in) disable iff (rst)
    !wrap_evt |=> !$rose(word_clk));

  // R2: the word taken at a wrap is the cascade plus the incoming bit.
  assert_capture_order_R2: assert property (@(posedge clk_in) disable iff (rst)
    wrap_evt |=> par_out == $past({stages[WORD_W-2:0], ser_in}));

  // R5: during reset the outputs sit at their cleared values one edge later.
  assert_reset_clear_R5: assert property (@(posedge clk_in)
    rst |=> (par_out == '0) && word_clk);

endmodule

// File: tb/tb_s2p_converter.sv
`timescale 1ns/1ps
module tb_s2p_converter;

  localparam int NWORDS = 6;
  localparam logic [7:0] WORDS [0:NWORDS-1] = '{
    8'b10011001, 8'b01010111, 8'b00001111,
    8'b11111111, 8'b00000000, 8'b10000000
  };

  logic       clk_in = 1'b0;
  logic       rst;
  logic       ser_in;
  logic [7:0] par_out;
  logic       word_clk;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  int         edges;
  logic [7:0] model_sh;
  logic [7:0] model_hold;

  always #2.5 clk_in = ~clk_in;

  s2p_converter dut (
    .clk_in  (clk_in),
    .rst     (rst),
    .ser_in  (ser_in),
    .par_out (par_out),
    .word_clk(word_clk)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b (edge %0d)", tag, act, exp, edges);
    end
  endtask

  // One input cycle: drive a bit, let the edge pass, check at the falling edge.
  task automatic step(input logic b);
    ser_in = b;
    @(posedge clk_in);
    edges++;
    model_sh = {model_sh[6:0], b};
    if (edges % 8 == 0) model_hold = model_sh;
    @(negedge clk_in);
    check(par_out == model_hold, "R3 hold value", par_out, model_hold);
    check(word_clk == ((edges % 8) < 4), "R4 word clock phase",
          {7'd0, word_clk}, {7'd0, 1'((edges % 8) < 4)});
  endtask

  task automatic restart_model();
    edges = 0;
    model_sh = '0;
    model_hold = '0;
  endtask

  initial begin
    rst = 1'b1;
    ser_in = 1'b0;
    restart_model();
    repeat (3) @(negedge clk_in);
    // R5: cleared state during reset
    check(par_out == 8'h00, "R5 reset par_out", par_out, 8'h00);
    check(word_clk == 1'b1, "R5 reset word_clk", {7'd0, word_clk}, 8'd1);
    rst = 1'b0;

    // Table walk: back-to-back words, MSB first (R1, R2, R7).
    for (int w = 0; w < NWORDS; w++) begin
      for (int b = 7; b >= 0; b--) step(WORDS[w][b]);
      check(par_out == WORDS[w], "R2 R7 word capture", par_out, WORDS[w]);
      check(word_clk == 1'b1, "R4 rise at capture", {7'd0, word_clk}, 8'd1);
    end

    // R1: single one walking through the cascade lands at D0 when last.
    for (int b = 7; b >= 0; b--) step(b == 0);
    check(par_out == 8'b00000001, "R1 last bit at D0", par_out, 8'b00000001);

    // Reset in the middle of a word: alignment restarts (R5, R6).
    step(1'b1); step(1'b0); step(1'b1);
    rst = 1'b1;
    @(posedge clk_in);
    @(negedge clk_in);
    check(par_out == 8'h00, "R5 mid-word reset par_out", par_out, 8'h00);
    check(word_clk == 1'b1, "R5 mid-word reset word_clk", {7'd0, word_clk}, 8'd1);
    rst = 1'b0;
    restart_model();
    for (int b = 7; b >= 1; b--) step(8'hA5 >> b);
    check(par_out == 8'h00, "R6 no capture before 8th edge", par_out, 8'h00);
    step(1'b1);
    check(par_out == 8'hA5, "R6 capture on 8th edge", par_out, 8'hA5);

    // R3: during the next word the output keeps the previous word.
    for (int b = 7; b >= 1; b--) begin
      step(1'b0);
      check(par_out == 8'hA5, "R3 stable between captures", par_out, 8'hA5);
    end
    step(1'b0);
    check(par_out == 8'h00, "R7 following word", par_out, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule